// File: doc/BRIEF.md
# External Bus Hold Controller

This block sits between a processor core and a multiplexed external bus and lets an outside master take over that bus. The master raises an asynchronous request line. The block synchronises the request and records it as pending. It hands the bus over only when the core reports a safe point, which is the end of an instruction or the end of one element of a string operation. While the outside master owns the bus, the block drives an active-low acknowledge. It also turns off the drivers of three pin groups: the address outputs, the multiplexed address/data lines, and the bus control strobes. It stalls the core for the same period.

When the request falls, the block first turns the pin drivers back on, then raises the acknowledge, and then lets the core run one cycle later. The block refuses requests while the hold-enable bit is clear or while the device is in stop mode. A separate small machine stretches automatic wait cycles. When ready checking is enabled and the ready input is low at the end of an automatic wait cycle, the machine asks the core to keep waiting until ready goes high.

Hold states: `HS_IDLE` (bus owned by the core), `HS_PEND` (request accepted, waiting for a boundary), `HS_HELD` (bus granted and pins floating), `HS_REDRIVE` (pins driven again, acknowledge still low), `HS_RESUME` (acknowledge high, core still stalled). Hold transitions:
- IDLE→PEND when a qualified request is seen.
- PEND→IDLE when the request is cancelled.
- PEND→HELD on a boundary.
- HELD→REDRIVE when the request drops.
- REDRIVE→RESUME and RESUME→IDLE unconditionally.

Wait states: `WS_IDLE` and `WS_EXTEND`. Wait transitions:
- IDLE→EXTEND when an automatic wait ends while ready is low and ready checking is enabled.
- EXTEND→IDLE when ready is high.

Top module: `ext_bus_hold_ctrl`

## Requirements
- R1: After reset, `hold_ack_n` is 1, all three output enables are 1, and `core_stall` and `wait_extend` are 0.
- R2: While `hold_en` is 0, a high `hold_req` never causes `hold_ack_n` to go low.
- R3: `hold_req` passes through a two-flop synchroniser. A request that has been high for three rising edges is pending. `hold_ack_n` falls at the first rising edge at which `insn_boundary` is 1 while the request is pending, and never at any other edge.
- R4: While `hold_ack_n` is 0 with the bus released to the outside master, `addr_oe`, `ad_oe` and `ctrl_oe` are 0 and `core_stall` is 1. `core_stall` is already 1 during the granting boundary cycle.
- R5: On the third rising edge after `hold_req` goes low, all three output enables return to 1 while `hold_ack_n` stays 0. `hold_ack_n` returns to 1 one edge later.
- R6: `core_stall` stays 1 for exactly one cycle after `hold_ack_n` returns to 1, then goes to 0.
- R7: While `stop_mode` is 1, no request is accepted, and `hold_ack_n` stays 1 even when boundaries occur.
- R8: If the request drops while pending and before any boundary, the pending grant is cancelled and `hold_ack_n` never goes low.
- R9: With `rdy_en` at 1, if `ready` is 0 in a cycle where `auto_wait_end` is 1, `wait_extend` is 1 in that same cycle.
- R10: After such a start, `wait_extend` stays 1 in every following cycle while `ready` is 0, and it is 0 in the first cycle in which `ready` is 1.
- R11: With `rdy_en` at 0, or with `ready` at 1 at the end of the automatic wait, `wait_extend` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hold_en | input | 1 | Hold function enable bit |
| rdy_en | input | 1 | Ready-driven wait extension enable bit |
| hold_req | input | 1 | Asynchronous hold request, high asks for the bus |
| insn_boundary | input | 1 | Core is at an instruction or string-element boundary |
| stop_mode | input | 1 | Device is in stop mode |
| auto_wait_end | input | 1 | Last cycle of an automatic wait sequence |
| ready | input | 1 | Ready input, synchronous to clk, low asks for more wait |
| hold_ack_n | output | 1 | Hold acknowledge, active low |
| core_stall | output | 1 | Holds the core while the bus is given away |
| addr_oe | output | 1 | Drive enable for the address outputs |
| ad_oe | output | 1 | Drive enable for the multiplexed address/data lines |
| ctrl_oe | output | 1 | Drive enable for the bus control strobes |
| wait_extend | output | 1 | Asks the core to insert a further wait cycle |

## Verification
The embedded assertions check five rules on every cycle:
- Acknowledge always implies stall.
- Pins float only while acknowledge is low.
- The acknowledge falls only after a boundary and never just after a cycle in stop mode.
- The drivers are on in the cycle before and the cycle of the acknowledge rise.
- A wait extension starts only from a low-ready automatic wait end.

The exact latency is shown only by the bench's scenarios: the three-edge synchroniser delay, the release sequence that spans three edges, and the cancellation of a pending grant. The same applies to the effect of a cleared enable bit and to the length of a ready-driven wait.

// File: rtl/hold_pkg.sv
package hold_pkg;

    typedef enum logic [2:0] {
        HS_IDLE    = 3'd0,
        HS_PEND    = 3'd1,
        HS_HELD    = 3'd2,
        HS_REDRIVE = 3'd3,
        HS_RESUME  = 3'd4
    } hold_state_e;

    typedef enum logic {
        WS_IDLE   = 1'b0,
        WS_EXTEND = 1'b1
    } wait_state_e;

endpackage

// File: rtl/hold_req_sync.sv
module hold_req_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);
    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= async_i;
            end
        end else begin : g_multi
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= {chain_q[STAGES-2:0], async_i};
            end
        end
    endgenerate

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/hold_fsm.sv
module hold_fsm
    import hold_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hold_en,
    input  logic req_sync,
    input  logic insn_boundary,
    input  logic stop_mode,
    output logic hold_ack_n,
    output logic core_stall,
    output logic pins_oe
);
    hold_state_e state_q, state_d;
    logic        req_ok;

    assign req_ok = hold_en && req_sync && !stop_mode;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= HS_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            HS_IDLE:    if (req_ok) state_d = HS_PEND;
            HS_PEND: begin
                if (!req_ok)           state_d = HS_IDLE;
                else if (insn_boundary) state_d = HS_HELD;
            end
            HS_HELD:    if (!req_sync) state_d = HS_REDRIVE;
            HS_REDRIVE: state_d = HS_RESUME;
            HS_RESUME:  state_d = HS_IDLE;
            default:    state_d = HS_IDLE;
        endcase
    end

    always_comb begin
        hold_ack_n = 1'b1;
        core_stall = 1'b0;
        pins_oe    = 1'b1;
        unique case (state_q)
            HS_IDLE: ;
            HS_PEND:    core_stall = req_ok && insn_boundary;
            HS_HELD: begin
                hold_ack_n = 1'b0;
                core_stall = 1'b1;
                pins_oe    = 1'b0;
            end
            HS_REDRIVE: begin
                hold_ack_n = 1'b0;
                core_stall = 1'b1;
            end
            HS_RESUME:  core_stall = 1'b1;
            default: ;
        endcase
    end

    // R4: an asserted acknowledge always comes with a stalled core
    a_r4_ack_stalls: assert property (@(posedge clk) disable iff (!rst_n)
        !hold_ack_n |-> core_stall);

    // R4: pins float only while the acknowledge is low
    a_r4_float_only_acked: assert property (@(posedge clk) disable iff (!rst_n)
        !pins_oe |-> !hold_ack_n);

    // R3: a grant follows a boundary cycle
    a_r3_grant_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hold_ack_n) |-> $past(insn_boundary));

    // R7: no grant out of a stop-mode cycle
    a_r7_no_grant_in_stop: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hold_ack_n) |-> !$past(stop_mode));

    // R5: drivers are back on before the acknowledge rises
    a_r5_redrive_first: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hold_ack_n) |-> (pins_oe && $past(pins_oe)));

    // R6: stall outlasts the acknowledge
    a_r6_stall_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hold_ack_n) |-> core_stall);
endmodule

// File: rtl/ready_wait_ext.sv
module ready_wait_ext
    import hold_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic rdy_en,
    input  logic auto_wait_end,
    input  logic ready,
    output logic wait_extend
);
    wait_state_e wstate_q, wstate_d;
    logic        start_ext;

    assign start_ext = rdy_en && auto_wait_end && !ready;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) wstate_q <= WS_IDLE;
        else        wstate_q <= wstate_d;
    end

    always_comb begin
        wstate_d    = wstate_q;
        wait_extend = 1'b0;
        unique case (wstate_q)
            WS_IDLE: begin
                wait_extend = start_ext;
                if (start_ext) wstate_d = WS_EXTEND;
            end
            WS_EXTEND: begin
                wait_extend = !ready;
                if (ready) wstate_d = WS_IDLE;
            end
            default: wstate_d = WS_IDLE;
        endcase
    end

    // R9: an extension only begins from a low-ready automatic wait end
    a_r9_start_cause: assert property (@(posedge clk) disable iff (!rst_n)
        (wstate_q == WS_EXTEND && $past(wstate_q) == WS_IDLE)
            |-> $past(rdy_en && auto_wait_end && !ready));

    // R10: while extending, a low ready keeps the wait going
    a_r10_hold_wait: assert property (@(posedge clk) disable iff (!rst_n)
        (wstate_q == WS_EXTEND && !ready) |-> wait_extend);
endmodule

// File: rtl/ext_bus_hold_ctrl.sv
module ext_bus_hold_ctrl #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hold_en,
    input  logic rdy_en,
    input  logic hold_req,
    input  logic insn_boundary,
    input  logic stop_mode,
    input  logic auto_wait_end,
    input  logic ready,
    output logic hold_ack_n,
    output logic core_stall,
    output logic addr_oe,
    output logic ad_oe,
    output logic ctrl_oe,
    output logic wait_extend
);
    logic req_sync;
    logic pins_oe;

    hold_req_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (hold_req),
        .sync_o  (req_sync)
    );

    hold_fsm u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .hold_en       (hold_en),
        .req_sync      (req_sync),
        .insn_boundary (insn_boundary),
        .stop_mode     (stop_mode),
        .hold_ack_n    (hold_ack_n),
        .core_stall    (core_stall),
        .pins_oe       (pins_oe)
    );

    ready_wait_ext u_wait (
        .clk           (clk),
        .rst_n         (rst_n),
        .rdy_en        (rdy_en),
        .auto_wait_end (auto_wait_end),
        .ready         (ready),
        .wait_extend   (wait_extend)
    );

    assign addr_oe = pins_oe;
    assign ad_oe   = pins_oe;
    assign ctrl_oe = pins_oe;

    // R1: after reset the bus is driven and not acknowledged
    a_r1_reset_idle: assert property (@(posedge clk)
        $rose(rst_n) |-> (hold_ack_n && addr_oe && ad_oe && ctrl_oe));
endmodule

// File: tb/ext_bus_hold_ctrl_tb.sv
module ext_bus_hold_ctrl_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic hold_en = 1'b0, rdy_en = 1'b0, hold_req = 1'b0, insn_boundary = 1'b0;
    logic stop_mode = 1'b0, auto_wait_end = 1'b0, ready = 1'b1;
    logic hold_ack_n, core_stall, addr_oe, ad_oe, ctrl_oe, wait_extend;
    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    ext_bus_hold_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .hold_en(hold_en), .rdy_en(rdy_en),
        .hold_req(hold_req), .insn_boundary(insn_boundary), .stop_mode(stop_mode),
        .auto_wait_end(auto_wait_end), .ready(ready), .hold_ack_n(hold_ack_n),
        .core_stall(core_stall), .addr_oe(addr_oe), .ad_oe(ad_oe),
        .ctrl_oe(ctrl_oe), .wait_extend(wait_extend)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    // {ack_n, stall, addr_oe, ad_oe, ctrl_oe}
    function automatic logic [7:0] bus_vec();
        return {3'b000, hold_ack_n, core_stall, addr_oe, ad_oe, ctrl_oe};
    endfunction

    task automatic t_reset();
        step(1);
        chk("R1 reset outputs", bus_vec(), 8'b000_10111);
        chk("R1 reset wait", {7'd0, wait_extend}, 8'd0);
        rst_n = 1'b1;
        step(1);
        chk("R1 after release", bus_vec(), 8'b000_10111);
    endtask

    task automatic t_grant_release();
        hold_en = 1'b1;
        hold_req = 1'b1;
        step(2);
        chk("R3 not pending yet", bus_vec(), 8'b000_10111);
        step(1);
        chk("R3 pending no grant", bus_vec(), 8'b000_10111);
        step(2);
        chk("R3 waits for boundary", bus_vec(), 8'b000_10111);
        insn_boundary = 1'b1;
        #1 chk("R4 stall in boundary cycle", {7'd0, core_stall}, 8'd1);
        step(1);
        insn_boundary = 1'b0;
        chk("R4 held outputs", bus_vec(), 8'b000_01000);
        step(4);
        chk("R4 still held", bus_vec(), 8'b000_01000);
        hold_req = 1'b0;
        step(2);
        chk("R5 still held during sync", bus_vec(), 8'b000_01000);
        step(1);
        chk("R5 redrive before ack", bus_vec(), 8'b000_01111);
        step(1);
        chk("R6 ack high stall kept", bus_vec(), 8'b000_11111);
        step(1);
        chk("R6 stall released", bus_vec(), 8'b000_10111);
    endtask

    task automatic t_disabled();
        hold_en = 1'b0;
        hold_req = 1'b1;
        for (int i = 0; i < 6; i++) begin
            insn_boundary = 1'b1;
            step(1);
        end
        insn_boundary = 1'b0;
        chk("R2 disabled ignores request", bus_vec(), 8'b000_10111);
        hold_req = 1'b0;
        hold_en = 1'b1;
        step(4);
    endtask

    task automatic t_stop();
        stop_mode = 1'b1;
        hold_req = 1'b1;
        for (int i = 0; i < 6; i++) begin
            insn_boundary = 1'b1;
            step(1);
        end
        insn_boundary = 1'b0;
        chk("R7 stop refuses", bus_vec(), 8'b000_10111);
        hold_req = 1'b0;
        step(4);
        stop_mode = 1'b0;
    endtask

    task automatic t_cancel();
        int lows = 0;
        hold_req = 1'b1;
        step(3);
        hold_req = 1'b0;
        for (int i = 0; i < 4; i++) begin
            step(1);
            if (!hold_ack_n) lows++;
        end
        insn_boundary = 1'b1;
        step(1);
        insn_boundary = 1'b0;
        if (!hold_ack_n) lows++;
        chk("R8 cancel no ack", lows[7:0], 8'd0);
        chk("R8 idle after cancel", bus_vec(), 8'b000_10111);
    endtask

    task automatic t_ready();
        rdy_en = 1'b1;
        ready = 1'b0;
        auto_wait_end = 1'b1;
        #1 chk("R9 extend starts", {7'd0, wait_extend}, 8'd1);
        step(1);
        auto_wait_end = 1'b0;
        chk("R10 extend holds 1", {7'd0, wait_extend}, 8'd1);
        step(2);
        chk("R10 extend holds 3", {7'd0, wait_extend}, 8'd1);
        ready = 1'b1;
        #1 chk("R10 ends on ready", {7'd0, wait_extend}, 8'd0);
        step(1);
        chk("R10 idle after", {7'd0, wait_extend}, 8'd0);
        auto_wait_end = 1'b1;
        #1 chk("R11 ready high no extend", {7'd0, wait_extend}, 8'd0);
        step(1);
        rdy_en = 1'b0;
        ready = 1'b0;
        #1 chk("R11 disabled no extend", {7'd0, wait_extend}, 8'd0);
        step(1);
        auto_wait_end = 1'b0;
        chk("R11 disabled stays idle", {7'd0, wait_extend}, 8'd0);
        ready = 1'b1;
    endtask

    initial begin
        t_reset();
        t_grant_release();
        t_disabled();
        t_stop();
        t_cancel();
        t_ready();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                total++;
                bad++;
                $display("FAIL watchdog expired");
            end
        join_any
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule